// File: doc/BRIEF.md
# Dual-Set USB Host Transaction Register File

This block is the register file that a CPU uses to program a small USB host transaction engine. The CPU reaches it through an 8-bit address bus with RAM-style read and write strobes. The lowest sixteen addresses are registers. Every higher address belongs to the packet data buffer: the block only flags such an access and does not store anything for it.

Two identical descriptor sets, A and B, each hold a control byte, a buffer base, a buffer length, a PID/endpoint byte and a device address. At two offsets in each set, a read returns data that the engine produced: the status of the last transaction and the remaining count. The engine always works on the "current" set. While that set's arm bit (control bit 0) is 1, the engine may finish a transfer. When it does, the block drops the arm bit, captures status and count, and raises a done flag. If set B has been enabled, the block also hands the engine to the other set. Set B is enabled by a sticky bit that any write to address 0Fh turns on. Until then, set A stays current forever.

Top module: `usb_host_regfile`

## Requirements
- R1: After reset, both control bytes (00h, 08h), 05h, 07h, the status flags at 0Dh and the SOF low byte read as zero, `eng_go` and `irq` are 0, and set A is current (`eng_set`=0).
- R2: Addresses 00h, 01h, 02h, 05h, 06h, 07h, 08h, 09h, 0Ah and 0Fh read back the byte last written to them. `cpu_rdata` is 0 whenever `cpu_rd` is low.
- R3: A write to 03h (set A) or 0Bh (set B) stores that set's PID/endpoint byte, which appears on `eng_pid_ep` while that set is current. A read of the same address returns that set's last captured transaction status.
- R4: A write to 04h or 0Ch stores that set's device address, which appears on `eng_dev_addr` while that set is current. A read returns that set's last captured count.
- R5: A write to 0Eh loads the SOF low byte, seen on `sof_period[7:0]`. A read of 0Eh returns the parameter `HW_REV`. `sof_period[13:8]` is bits 5:0 of the 0Fh byte.
- R6: An access to 10h–FFh raises `buf_sel` in the same cycle, changes no register, and reads back 0.
- R7: The dual-set enable is set by any write to 0Fh, whatever the data, and stays set until reset. While it is clear, set A stays current even after completions.
- R8: While the dual-set enable is set, each accepted completion moves the current set to the other one.
- R9: `eng_go` equals the arm bit of the current set. An accepted completion clears that bit and captures `eng_status` and `eng_count` into the set's read-side registers. If a CPU write to that control byte falls in the same cycle, the write's other bits are kept but bit 0 still ends as 0.
- R10: Status register 0Dh holds a done flag per set: bit 0 for A, bit 1 for B. Its other bits read 0. A completion sets the flag of the finishing set. Writing 1 to a flag clears it. If a completion and a clear of the same flag fall in the same cycle, the flag stays set.
- R11: `irq` is high exactly while some done flag is set and its matching bit (bit 0 for A, bit 1 for B) of the interrupt-enable byte at 06h is 1.
- R12: An `eng_done` pulse while `eng_go` is 0 changes nothing: no flag, no capture, no change of the current set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 8 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe |
| cpu_rdata | output | 8 | Read data, combinational from address |
| buf_sel | output | 1 | Access falls in the data buffer range |
| eng_done | input | 1 | Engine finished the current set's transfer |
| eng_status | input | 8 | Transaction status to capture |
| eng_count | input | 8 | Remaining count to capture |
| eng_go | output | 1 | Current set is armed |
| eng_set | output | 1 | Current set, 0 = A, 1 = B |
| eng_base | output | 8 | Buffer base of current set |
| eng_len | output | 8 | Buffer length of current set |
| eng_pid_ep | output | 8 | PID/endpoint of current set |
| eng_dev_addr | output | 8 | Device address of current set |
| ctrl1 | output | 8 | Global control byte (05h) |
| sof_period | output | 14 | SOF reload value |
| irq | output | 1 | Interrupt to the CPU |

## Verification
Two kinds of event can land in the same clock edge. One is a completion from the engine. The other is a CPU write to a register that the completion also updates: the status flags at 0Dh, or the current set's control byte. The bench provokes both collisions on purpose. It raises `eng_done` in the same cycle as a write of 03h to 0Dh, and in the same cycle as a write that re-arms the set that is finishing. A behavioural model applies the CPU write first and the completion after it. Each cycle the bench compares the flags, `irq`, `eng_go` and the current set against that model. The outcomes it expects are that the flag survives, the arm bit ends as 0, and the hand-over to the other set still happens.

// File: rtl/usb_host_regfile.sv
module usb_host_regfile #(
  parameter logic [7:0] HW_REV = 8'h20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  output logic [7:0]  cpu_rdata,
  output logic        buf_sel,
  input  logic        eng_done,
  input  logic [7:0]  eng_status,
  input  logic [7:0]  eng_count,
  output logic        eng_go,
  output logic        eng_set,
  output logic [7:0]  eng_base,
  output logic [7:0]  eng_len,
  output logic [7:0]  eng_pid_ep,
  output logic [7:0]  eng_dev_addr,
  output logic [7:0]  ctrl1,
  output logic [13:0] sof_period,
  output logic        irq
);
  logic [7:0] ctl_q [2];
  logic [7:0] base_q [2];
  logic [7:0] len_q [2];
  logic [7:0] pid_q [2];
  logic [7:0] dev_q [2];
  logic [7:0] st_q [2];
  logic [7:0] cnt_q [2];
  logic [7:0] ctrl1_q, ie_q, rsv_q, sofl_q, ctrl2_q;
  logic [1:0] done_q;
  logic       full_en, cur;

  wire       reg_hit  = (cpu_addr[7:4] == 4'h0);
  wire       bsel     = cpu_addr[3];
  wire [2:0] off      = cpu_addr[2:0];
  wire       per_set  = (off <= 3'd4);
  wire       xfer_end = eng_done & ctl_q[cur][0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        ctl_q[i]  <= '0;
        base_q[i] <= '0;
        len_q[i]  <= '0;
        pid_q[i]  <= '0;
        dev_q[i]  <= '0;
        st_q[i]   <= '0;
        cnt_q[i]  <= '0;
      end
      ctrl1_q <= '0;
      ie_q    <= '0;
      rsv_q   <= '0;
      sofl_q  <= '0;
      ctrl2_q <= '0;
      done_q  <= '0;
      full_en <= 1'b0;
      cur     <= 1'b0;
    end else begin
      if (cpu_wr && reg_hit) begin
        if (per_set) begin
          case (off)
            3'd0:    ctl_q[bsel]  <= cpu_wdata;
            3'd1:    base_q[bsel] <= cpu_wdata;
            3'd2:    len_q[bsel]  <= cpu_wdata;
            3'd3:    pid_q[bsel]  <= cpu_wdata;
            default: dev_q[bsel]  <= cpu_wdata;
          endcase
        end else begin
          case ({bsel, off})
            4'h5: ctrl1_q <= cpu_wdata;
            4'h6: ie_q    <= cpu_wdata;
            4'h7: rsv_q   <= cpu_wdata;
            4'hD: done_q  <= done_q & ~cpu_wdata[1:0];
            4'hE: sofl_q  <= cpu_wdata;
            4'hF: begin
              ctrl2_q <= cpu_wdata;
              full_en <= 1'b1;
            end
            default: ;
          endcase
        end
      end
      if (xfer_end) begin
        ctl_q[cur][0] <= 1'b0;
        st_q[cur]     <= eng_status;
        cnt_q[cur]    <= eng_count;
        done_q[cur]   <= 1'b1;
        if (full_en) cur <= ~cur;
      end
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd && reg_hit) begin
      if (per_set) begin
        case (off)
          3'd0:    cpu_rdata = ctl_q[bsel];
          3'd1:    cpu_rdata = base_q[bsel];
          3'd2:    cpu_rdata = len_q[bsel];
          3'd3:    cpu_rdata = st_q[bsel];
          default: cpu_rdata = cnt_q[bsel];
        endcase
      end else begin
        case ({bsel, off})
          4'h5:    cpu_rdata = ctrl1_q;
          4'h6:    cpu_rdata = ie_q;
          4'h7:    cpu_rdata = rsv_q;
          4'hD:    cpu_rdata = {6'b0, done_q};
          4'hE:    cpu_rdata = HW_REV;
          default: cpu_rdata = ctrl2_q;
        endcase
      end
    end
  end

  assign buf_sel      = (cpu_rd | cpu_wr) & ~reg_hit;
  assign eng_go       = ctl_q[cur][0];
  assign eng_set      = cur;
  assign eng_base     = base_q[cur];
  assign eng_len      = len_q[cur];
  assign eng_pid_ep   = pid_q[cur];
  assign eng_dev_addr = dev_q[cur];
  assign ctrl1        = ctrl1_q;
  assign sof_period   = {ctrl2_q[5:0], sofl_q};
  assign irq          = |(done_q & ie_q[1:0]);
endmodule

module usb_host_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_wr,
  input logic [7:0] cpu_addr,
  input logic       eng_done,
  input logic       eng_go,
  input logic       eng_set,
  input logic [7:0] eng_base,
  input logic       irq,
  input logic       full_en,
  input logic [1:0] done_q,
  input logic [7:0] ie_q
);
  AST_B_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n) !full_en |-> !eng_set); // R7
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) full_en |=> full_en); // R7
  AST_SWAP_ON_END: assert property (@(posedge clk) disable iff (!rst_n) eng_done && eng_go && full_en |=> eng_set != $past(eng_set)); // R8
  AST_ARM_DROP: assert property (@(posedge clk) disable iff (!rst_n) eng_done && eng_go && !full_en |=> !eng_go); // R9
  AST_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n) eng_done && eng_go && !eng_set |=> done_q[0]); // R10
  AST_IRQ_ON_END: assert property (@(posedge clk) disable iff (!rst_n) eng_done && eng_go && ie_q[eng_set] && !(cpu_wr && cpu_addr == 8'h06) |=> irq); // R11
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n) !(eng_done && eng_go) |=> $stable(eng_set)); // R12
  AST_BUF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) cpu_wr && cpu_addr[7:4] != 4'h0 && !eng_done |=> $stable(eng_base)); // R6
endmodule

bind usb_host_regfile usb_host_regfile_chk u_chk (.*);

// File: tb/sim_usb_host_regfile.sv
module sim_usb_host_regfile;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] REV = 8'h2C;

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wd = 0, st = 0, cn = 0;
  logic wr = 0, rd = 0, dn = 0;
  logic [7:0] rdata, base, len, pid, dev, c1;
  logic [13:0] sofp;
  logic bsel, go, eset, irq;

  usb_host_regfile #(.HW_REV(REV)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_wdata(wd), .cpu_wr(wr), .cpu_rd(rd),
    .cpu_rdata(rdata), .buf_sel(bsel), .eng_done(dn), .eng_status(st), .eng_count(cn),
    .eng_go(go), .eng_set(eset), .eng_base(base), .eng_len(len), .eng_pid_ep(pid),
    .eng_dev_addr(dev), .ctrl1(c1), .sof_period(sofp), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  string tag = "R1";
  bit finished = 0;

  logic [7:0] m_ctl[2], m_base[2], m_len[2], m_pid[2], m_dev[2], m_st[2], m_cnt[2];
  logic [7:0] m_c1, m_ie, m_r7, m_sofl, m_c2;
  logic [1:0] m_done;
  bit m_full, m_cur;

  task automatic chk(string f, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, f, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_ctl[i] = 0; m_base[i] = 0; m_len[i] = 0; m_pid[i] = 0;
      m_dev[i] = 0; m_st[i] = 0; m_cnt[i] = 0;
    end
    m_c1 = 0; m_ie = 0; m_r7 = 0; m_sofl = 0; m_c2 = 0;
    m_done = 0; m_full = 0; m_cur = 0;
  endtask

  function automatic logic [7:0] exp_rd();
    int s = addr[3];
    if (!rd || addr >= 8'h10) return 8'h00;
    case (addr[3:0])
      4'h0, 4'h8: return m_ctl[s];
      4'h1, 4'h9: return m_base[s];
      4'h2, 4'hA: return m_len[s];
      4'h3, 4'hB: return m_st[s];
      4'h4, 4'hC: return m_cnt[s];
      4'h5: return m_c1;
      4'h6: return m_ie;
      4'h7: return m_r7;
      4'hD: return {6'b0, m_done};
      4'hE: return REV;
      default: return m_c2;
    endcase
  endfunction

  task automatic compare_all();
    chk("rdata", 16'(rdata), 16'(exp_rd()));
    chk("buf_sel", 16'(bsel), 16'((rd || wr) && addr >= 8'h10));
    chk("eng_go", 16'(go), 16'(m_ctl[m_cur][0]));
    chk("eng_set", 16'(eset), 16'(m_cur));
    chk("eng_base", 16'(base), 16'(m_base[m_cur]));
    chk("eng_len", 16'(len), 16'(m_len[m_cur]));
    chk("eng_pid_ep", 16'(pid), 16'(m_pid[m_cur]));
    chk("eng_dev_addr", 16'(dev), 16'(m_dev[m_cur]));
    chk("ctrl1", 16'(c1), 16'(m_c1));
    chk("sof_period", 16'(sofp), {2'b0, m_c2[5:0], m_sofl});
    chk("irq", 16'(irq), 16'(|(m_done & m_ie[1:0])));
  endtask

  task automatic model_step();
    bit fin = dn && m_ctl[m_cur][0];
    bit c = m_cur;
    bit f_old = m_full;
    int s = addr[3];
    if (wr && addr < 8'h10) begin
      case (addr[3:0])
        4'h0, 4'h8: m_ctl[s] = wd;
        4'h1, 4'h9: m_base[s] = wd;
        4'h2, 4'hA: m_len[s] = wd;
        4'h3, 4'hB: m_pid[s] = wd;
        4'h4, 4'hC: m_dev[s] = wd;
        4'h5: m_c1 = wd;
        4'h6: m_ie = wd;
        4'h7: m_r7 = wd;
        4'hD: m_done = m_done & ~wd[1:0];
        4'hE: m_sofl = wd;
        default: begin m_c2 = wd; m_full = 1; end
      endcase
    end
    if (fin) begin
      m_ctl[c][0] = 0;
      m_st[c] = st;
      m_cnt[c] = cn;
      m_done[c] = 1;
      if (f_old) m_cur = !c;
    end
  endtask

  task automatic tick(bit w, bit r, logic [7:0] a, logic [7:0] d, bit e = 0,
                      logic [7:0] s = 0, logic [7:0] n = 0);
    @(negedge clk);
    wr = w; rd = r; addr = a; wd = d; dn = e; st = s; cn = n;
    #1;
    compare_all();
    model_step();
  endtask

  task automatic wrt(logic [7:0] a, logic [7:0] d); tick(1, 0, a, d); endtask
  task automatic rdd(logic [7:0] a); tick(0, 1, a, 0); endtask
  task automatic fin(logic [7:0] s, logic [7:0] n); tick(0, 0, 0, 0, 1, s, n); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    tag = "R1";
    rdd(8'h00); rdd(8'h08); rdd(8'h05); rdd(8'h07); rdd(8'h0D);

    tag = "R2";
    wrt(8'h01, 8'hA5); wrt(8'h02, 8'h3C); wrt(8'h05, 8'h81); wrt(8'h06, 8'h00);
    wrt(8'h07, 8'h7E); wrt(8'h09, 8'h5B); wrt(8'h0A, 8'hC3); wrt(8'h00, 8'hFE);
    rdd(8'h01); rdd(8'h02); rdd(8'h05); rdd(8'h07); rdd(8'h09); rdd(8'h0A); rdd(8'h00);
    tick(0, 0, 8'h01, 0);

    tag = "R3";
    wrt(8'h03, 8'h69); wrt(8'h0B, 8'hE1); rdd(8'h03); rdd(8'h0B);
    tag = "R4";
    wrt(8'h04, 8'h12); wrt(8'h0C, 8'h34); rdd(8'h04); rdd(8'h0C);
    tag = "R5";
    wrt(8'h0E, 8'h5A); rdd(8'h0E);

    tag = "R6";
    wrt(8'h10, 8'hFF); wrt(8'h80, 8'h11); wrt(8'hFF, 8'h22);
    rdd(8'h10); rdd(8'h7F); rdd(8'h01); rdd(8'h0E);

    tag = "R12";
    fin(8'h99, 8'h77); rdd(8'h0D); rdd(8'h03);

    tag = "R9";
    wrt(8'h00, 8'h01); tick(0, 0, 0, 0);
    fin(8'h13, 8'h05); rdd(8'h03); rdd(8'h04); rdd(8'h00);

    tag = "R7";
    wrt(8'h08, 8'h01); wrt(8'h00, 8'h01);
    fin(8'h22, 8'h01); rdd(8'h08); rdd(8'h0B);
    fin(8'h23, 8'h02); rdd(8'h03);
    wrt(8'h0D, 8'h03);

    tag = "R8";
    wrt(8'h0F, 8'h00); rdd(8'h0F);
    wrt(8'h0F, 8'h2A); rdd(8'h0F);
    wrt(8'h00, 8'h01);
    fin(8'h40, 8'h07); tick(0, 0, 0, 0);
    fin(8'h41, 8'h08); rdd(8'h0B); rdd(8'h0C); rdd(8'h03);

    tag = "R10";
    rdd(8'h0D); wrt(8'h0D, 8'h01); rdd(8'h0D);
    wrt(8'h00, 8'h01);
    tick(1, 0, 8'h0D, 8'h03, 1, 8'h55, 8'h09);
    rdd(8'h0D);

    tag = "R11";
    wrt(8'h06, 8'h02); wrt(8'h08, 8'h01); tick(0, 0, 0, 0);
    fin(8'h66, 8'h0A); rdd(8'h0D);
    wrt(8'h06, 8'h00); wrt(8'h06, 8'h03);
    wrt(8'h0D, 8'h02); wrt(8'h0D, 8'h01); tick(0, 0, 0, 0);

    tag = "R9";
    wrt(8'h00, 8'h01); wrt(8'h08, 8'h01);
    tick(1, 0, m_cur ? 8'h08 : 8'h00, 8'hF1, 1, 8'h77, 8'h0B);
    rdd(8'h00); rdd(8'h08);
    fin(8'h78, 8'h0C); rdd(8'h0D);
    tick(0, 0, 0, 0);

    tag = "R1";
    @(negedge clk); rst_n = 0; wr = 0; rd = 0; dn = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    rdd(8'h00); rdd(8'h08); rdd(8'h0D); rdd(8'h0F);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule